// File: doc/BRIEF.md
# Tagged Address Translation Cache with Permission Checking

This block sits between the memory stage of a pipeline and the first-level cache. Each cycle it can accept one lookup made of a 32-bit virtual address, a process tag (address-space identifier) and an access kind: instruction fetch, data load or data store. One clock later it reports one of three outcomes. The first is a translated physical address for the cache. The second is a permission fault. The third is a miss, which raises a request to an external page-table walker.

The store is a small fully associative array of 8 entries. Each entry carries a valid flag, a process tag, a global flag, the virtual page number, the physical page number and read, write and execute permission bits. Pages are 4 KiB, so the low 12 address bits pass through unchanged. Entries from different processes can live side by side, so a context switch needs no flush. When the walker returns an entry, it is written into the slot under a round-robin replacement pointer. The requester then retries the access.

A single-cycle flush command removes every non-global entry that belongs to one process tag.

Top module: `tlb_xlate`

## Requirements
- R1: After reset no response, walk request or address is driven (all outputs zero), and every entry is invalid, so the first lookup misses.
- R2: A lookup presented with `reqValid` in one cycle produces `rspValid` in the next cycle, with exactly one of `rspHit`, `rspMiss`, `rspFault` set. No response appears without a request.
- R3: On a miss, `walkReq` is high in the same cycle as `rspMiss`, `walkVpn`/`walkAsid` carry the page number (address bits 31:12) and tag of the lookup, and `rspPaddr` is zero.
- R4: On a hit that passes the permission check, `rspPaddr` equals the entry's physical page number concatenated with address bits 11:0 of the request.
- R5: `reqKind` encodes 0 = fetch, 1 = load, 2 = store, 3 = reserved. Permission bits are bit 0 = read, bit 1 = write, bit 2 = execute. Fetch needs execute, load needs read and store needs write; code 3 is never permitted. A hit that fails the check gives `rspFault` with `rspPaddr` zero.
- R6: An entry matches only if its page number equals the request's and its tag equals `reqAsid`. The tag comparison is skipped when the entry's global flag is set.
- R7: Each `fillValid` writes the slot under a replacement pointer that starts at 0 after reset and advances by one per fill, wrapping after slot 7. The ninth fill therefore evicts the first entry.
- R8: `flushValid` invalidates, in one cycle, every non-global entry whose tag equals `flushAsid`. Global entries and entries of other tags stay. If a fill arrives in the same cycle, the filled slot ends up valid.
- R9: A lookup issued in a cycle after a fill sees the new entry. A lookup in the same cycle as a fill sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Lookup strobe |
| reqVaddr | input | 32 | Virtual address of the lookup |
| reqAsid | input | 8 | Process tag of the lookup |
| reqKind | input | 2 | Access kind (0 fetch, 1 load, 2 store, 3 reserved) |
| rspValid | output | 1 | Response present |
| rspHit | output | 1 | Translation succeeded |
| rspMiss | output | 1 | No matching entry |
| rspFault | output | 1 | Matching entry forbids the access |
| rspPaddr | output | 32 | Physical address on a hit, else zero |
| walkReq | output | 1 | Refill request to the walker |
| walkVpn | output | 20 | Page number to walk |
| walkAsid | output | 8 | Tag of the walk |
| fillValid | input | 1 | Walker returns an entry |
| fillVpn | input | 20 | Virtual page number of the new entry |
| fillAsid | input | 8 | Tag of the new entry |
| fillPpn | input | 20 | Physical page number of the new entry |
| fillPerm | input | 3 | Permissions {execute, write, read} |
| fillGlobal | input | 1 | Entry matches any tag |
| flushValid | input | 1 | Flush-by-tag command |
| flushAsid | input | 8 | Tag to flush |

## Verification
The bench targets three groups of cases. The first is the three access kinds against each permission combination, including the reserved kind. A wrong check would hand out an address for a forbidden store or fetch, or fault a legal one. The second is a same-page lookup under a foreign tag, a global entry under any tag, and a flush that names the tag stored in a global entry. A design that mishandled any of these would leak translations across processes or would drop shared kernel mappings. The third is the ninth refill, plus a lookup made in the same cycle as a fill. A broken pointer shows up as the wrong survivor after the wrap, and a bypass shows up as a hit one cycle too early.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  localparam int PERM_W   = 3;
  localparam int PERM_RD  = 0;
  localparam int PERM_WR  = 1;
  localparam int PERM_EX  = 2;

  // Strobes from control to datapath
  typedef struct packed {
    logic fillWe;    // write fill into victim slot
    logic flushEn;   // invalidate matching non-global entries
    logic xlateOk;   // register translated address
    logic walkCap;   // register walk page/tag
  } tlb_strobe_t;

endpackage

// File: rtl/tlb_dpath.sv
module tlb_dpath
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = 3,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int ASID_W  = 8,
  parameter int PAGE_W  = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  tlb_strobe_t         strobe,
  input  logic [IDX_W-1:0]    victimIdx,
  input  logic [VPN_W-1:0]    reqVpn,
  input  logic [PAGE_W-1:0]   reqOffset,
  input  logic [ASID_W-1:0]   reqAsid,
  input  logic [VPN_W-1:0]    fillVpn,
  input  logic [ASID_W-1:0]   fillAsid,
  input  logic [PPN_W-1:0]    fillPpn,
  input  logic [PERM_W-1:0]   fillPerm,
  input  logic                fillGlobal,
  input  logic [ASID_W-1:0]   flushAsid,
  output logic                hitAny,
  output logic [PERM_W-1:0]   hitPerm,
  output logic [PPN_W+PAGE_W-1:0] rspPaddr,
  output logic [VPN_W-1:0]    walkVpn,
  output logic [ASID_W-1:0]   walkAsid
);

  logic                vldQ  [ENTRIES];
  logic                gblQ  [ENTRIES];
  logic [ASID_W-1:0]   asidQ [ENTRIES];
  logic [VPN_W-1:0]    vpnQ  [ENTRIES];
  logic [PPN_W-1:0]    ppnQ  [ENTRIES];
  logic [PERM_W-1:0]   permQ [ENTRIES];
  logic [ENTRIES-1:0]  matchVec;

  logic [PPN_W-1:0]    selPpn;

  for (genvar e = 0; e < ENTRIES; e++) begin : gEntry
    logic fillHere;
    logic flushHere;
    assign fillHere  = strobe.fillWe && (victimIdx == IDX_W'(e));
    assign flushHere = strobe.flushEn && !gblQ[e] && (asidQ[e] == flushAsid);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        vldQ[e] <= 1'b0;
      end else if (fillHere) begin
        vldQ[e] <= 1'b1;
      end else if (flushHere) begin
        vldQ[e] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        gblQ[e]  <= 1'b0;
        asidQ[e] <= '0;
        vpnQ[e]  <= '0;
        ppnQ[e]  <= '0;
        permQ[e] <= '0;
      end else if (fillHere) begin
        gblQ[e]  <= fillGlobal;
        asidQ[e] <= fillAsid;
        vpnQ[e]  <= fillVpn;
        ppnQ[e]  <= fillPpn;
        permQ[e] <= fillPerm;
      end
    end

    assign matchVec[e] = vldQ[e] && (vpnQ[e] == reqVpn) &&
                         (gblQ[e] || (asidQ[e] == reqAsid));
  end

  // Lowest matching slot wins
  always_comb begin
    selPpn  = '0;
    hitPerm = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (matchVec[i]) begin
        selPpn  = ppnQ[i];
        hitPerm = permQ[i];
      end
    end
  end

  assign hitAny = |matchVec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspPaddr <= '0;
      walkVpn  <= '0;
      walkAsid <= '0;
    end else begin
      rspPaddr <= strobe.xlateOk ? {selPpn, reqOffset} : '0;
      if (strobe.walkCap) begin
        walkVpn  <= reqVpn;
        walkAsid <= reqAsid;
      end
    end
  end

endmodule

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic              fillValid,
  input  logic              flushValid,
  input  logic              hitAny,
  input  logic [PERM_W-1:0] hitPerm,
  output tlb_strobe_t       strobe,
  output logic [IDX_W-1:0]  victimIdx,
  output logic              hitQ,
  output logic              missQ,
  output logic              faultQ
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic permOk;
  acc_e kind;

  assign kind = acc_e'(reqKind);

  always_comb begin
    unique case (kind)
      ACC_FETCH: permOk = hitPerm[PERM_EX];
      ACC_LOAD:  permOk = hitPerm[PERM_RD];
      ACC_STORE: permOk = hitPerm[PERM_WR];
      default:   permOk = 1'b0;
    endcase
  end

  always_comb begin
    strobe.fillWe  = fillValid;
    strobe.flushEn = flushValid;
    strobe.xlateOk = reqValid && hitAny && permOk;
    strobe.walkCap = reqValid && !hitAny;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      victimIdx <= '0;
    end else if (fillValid) begin
      victimIdx <= (victimIdx == LAST_IDX) ? '0 : victimIdx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hitQ   <= 1'b0;
      missQ  <= 1'b0;
      faultQ <= 1'b0;
    end else begin
      hitQ   <= reqValid && hitAny && permOk;
      missQ  <= reqValid && !hitAny;
      faultQ <= reqValid && hitAny && !permOk;
    end
  end

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int PAGE_W  = 12,
  parameter int ASID_W  = 8,
  parameter int ENTRIES = 8,
  localparam int VPN_W  = VA_W - PAGE_W,
  localparam int PPN_W  = PA_W - PAGE_W,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [VA_W-1:0]   reqVaddr,
  input  logic [ASID_W-1:0] reqAsid,
  input  logic [1:0]        reqKind,
  output logic              rspValid,
  output logic              rspHit,
  output logic              rspMiss,
  output logic              rspFault,
  output logic [PA_W-1:0]   rspPaddr,
  output logic              walkReq,
  output logic [VPN_W-1:0]  walkVpn,
  output logic [ASID_W-1:0] walkAsid,
  input  logic              fillValid,
  input  logic [VPN_W-1:0]  fillVpn,
  input  logic [ASID_W-1:0] fillAsid,
  input  logic [PPN_W-1:0]  fillPpn,
  input  logic [2:0]        fillPerm,
  input  logic              fillGlobal,
  input  logic              flushValid,
  input  logic [ASID_W-1:0] flushAsid
);

  tlb_strobe_t        strobe;
  logic [IDX_W-1:0]   victimIdx;
  logic               hitAny;
  logic [PERM_W-1:0]  hitPerm;

  tlb_ctrl #(
    .ENTRIES (ENTRIES),
    .IDX_W   (IDX_W)
  ) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqKind    (reqKind),
    .fillValid  (fillValid),
    .flushValid (flushValid),
    .hitAny     (hitAny),
    .hitPerm    (hitPerm),
    .strobe     (strobe),
    .victimIdx  (victimIdx),
    .hitQ       (rspHit),
    .missQ      (rspMiss),
    .faultQ     (rspFault)
  );

  tlb_dpath #(
    .ENTRIES (ENTRIES),
    .IDX_W   (IDX_W),
    .VPN_W   (VPN_W),
    .PPN_W   (PPN_W),
    .ASID_W  (ASID_W),
    .PAGE_W  (PAGE_W)
  ) dpath_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .victimIdx  (victimIdx),
    .reqVpn     (reqVaddr[VA_W-1:PAGE_W]),
    .reqOffset  (reqVaddr[PAGE_W-1:0]),
    .reqAsid    (reqAsid),
    .fillVpn    (fillVpn),
    .fillAsid   (fillAsid),
    .fillPpn    (fillPpn),
    .fillPerm   (fillPerm),
    .fillGlobal (fillGlobal),
    .flushAsid  (flushAsid),
    .hitAny     (hitAny),
    .hitPerm    (hitPerm),
    .rspPaddr   (rspPaddr),
    .walkVpn    (walkVpn),
    .walkAsid   (walkAsid)
  );

  assign rspValid = rspHit | rspMiss | rspFault;
  assign walkReq  = rspMiss;

endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
  parameter int VA_W   = 32,
  parameter int PA_W   = 32,
  parameter int PAGE_W = 12,
  parameter int ASID_W = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 reqValid,
  input logic [VA_W-1:0]      reqVaddr,
  input logic [ASID_W-1:0]    reqAsid,
  input logic                 rspValid,
  input logic                 rspHit,
  input logic                 rspMiss,
  input logic                 rspFault,
  input logic [PA_W-1:0]      rspPaddr,
  input logic                 walkReq,
  input logic [VA_W-PAGE_W-1:0] walkVpn,
  input logic [ASID_W-1:0]    walkAsid
);

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rspHit, rspMiss, rspFault})) else $error("outcome flags"); // R2

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid) else $error("missing response"); // R2

  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid) else $error("spurious response"); // R2

  AST_WALK_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (walkReq -> (walkVpn == $past(reqVaddr[VA_W-1:PAGE_W]) &&
                              walkAsid == $past(reqAsid)))) else $error("walk addr"); // R3

  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (rspHit -> (rspPaddr[PAGE_W-1:0] == $past(reqVaddr[PAGE_W-1:0]))))
    else $error("offset"); // R4

  AST_NO_ADDR_ON_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    (rspFault || rspMiss) |-> (rspPaddr == '0)) else $error("addr leak"); // R5

endmodule

bind tlb_xlate tlb_xlate_chk #(
  .VA_W   (VA_W),
  .PA_W   (PA_W),
  .PAGE_W (PAGE_W),
  .ASID_W (ASID_W)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqVaddr (reqVaddr),
  .reqAsid  (reqAsid),
  .rspValid (rspValid),
  .rspHit   (rspHit),
  .rspMiss  (rspMiss),
  .rspFault (rspFault),
  .rspPaddr (rspPaddr),
  .walkReq  (walkReq),
  .walkVpn  (walkVpn),
  .walkAsid (walkAsid)
);

// File: tb/tlb_xlate_tb_top.sv
module tlb_xlate_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqVaddr = '0;
  logic [7:0]  reqAsid = '0;
  logic [1:0]  reqKind = '0;
  logic        rspValid, rspHit, rspMiss, rspFault, walkReq;
  logic [31:0] rspPaddr;
  logic [19:0] walkVpn;
  logic [7:0]  walkAsid;
  logic        fillValid = 1'b0;
  logic [19:0] fillVpn = '0;
  logic [7:0]  fillAsid = '0;
  logic [19:0] fillPpn = '0;
  logic [2:0]  fillPerm = '0;
  logic        fillGlobal = 1'b0;
  logic        flushValid = 1'b0;
  logic [7:0]  flushAsid = '0;

  always #10 clk = ~clk;  // 50 MHz

  tlb_xlate dut_i (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqVaddr(reqVaddr), .reqAsid(reqAsid), .reqKind(reqKind),
    .rspValid(rspValid), .rspHit(rspHit), .rspMiss(rspMiss), .rspFault(rspFault),
    .rspPaddr(rspPaddr), .walkReq(walkReq), .walkVpn(walkVpn), .walkAsid(walkAsid),
    .fillValid(fillValid), .fillVpn(fillVpn), .fillAsid(fillAsid), .fillPpn(fillPpn),
    .fillPerm(fillPerm), .fillGlobal(fillGlobal),
    .flushValid(flushValid), .flushAsid(flushAsid)
  );

  int testCount = 0;
  int failCount = 0;

  // Behavioural reference: a plain list of translations
  bit        mV   [8];
  bit        mG   [8];
  bit [7:0]  mAs  [8];
  bit [19:0] mVpn [8];
  bit [19:0] mPpn [8];
  bit [2:0]  mPrm [8];
  int        mPtr = 0;

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic stepCycle(string tag);
    bit eHit, eMiss, eFault;
    bit [31:0] ePa;
    int found;
    bit ok;
    eHit = 0; eMiss = 0; eFault = 0; ePa = 0; found = -1;
    if (reqValid) begin
      for (int i = 0; i < 8; i++)
        if (found < 0 && mV[i] && mVpn[i] == reqVaddr[31:12] && (mG[i] || mAs[i] == reqAsid))
          found = i;
      if (found < 0) eMiss = 1;
      else begin
        case (reqKind)
          2'd0: ok = mPrm[found][2];
          2'd1: ok = mPrm[found][0];
          2'd2: ok = mPrm[found][1];
          default: ok = 0;
        endcase
        if (ok) begin eHit = 1; ePa = {mPpn[found], reqVaddr[11:0]}; end
        else eFault = 1;
      end
    end
    @(posedge clk);
    if (flushValid)
      for (int i = 0; i < 8; i++)
        if (!mG[i] && mAs[i] == flushAsid) mV[i] = 0;
    if (fillValid) begin
      mV[mPtr] = 1; mG[mPtr] = fillGlobal; mAs[mPtr] = fillAsid;
      mVpn[mPtr] = fillVpn; mPpn[mPtr] = fillPpn; mPrm[mPtr] = fillPerm;
      mPtr = (mPtr + 1) % 8;
    end
    @(negedge clk);
    check({tag, "/R2"}, "rspValid", 32'(rspValid), 32'(eHit | eMiss | eFault));
    check({tag, "/R4"}, "rspHit", 32'(rspHit), 32'(eHit));
    check({tag, "/R3"}, "rspMiss", 32'(rspMiss), 32'(eMiss));
    check({tag, "/R5"}, "rspFault", 32'(rspFault), 32'(eFault));
    check({tag, "/R4"}, "rspPaddr", rspPaddr, ePa);
    check({tag, "/R3"}, "walkReq", 32'(walkReq), 32'(eMiss));
    if (eMiss) begin
      check({tag, "/R3"}, "walkVpn", 32'(walkVpn), 32'(reqVaddr[31:12]));
      check({tag, "/R3"}, "walkAsid", 32'(walkAsid), 32'(reqAsid));
    end
    reqValid = 0; fillValid = 0; flushValid = 0;
  endtask

  task automatic setLookup(logic [1:0] kind, logic [31:0] va, logic [7:0] asid);
    reqValid = 1; reqKind = kind; reqVaddr = va; reqAsid = asid;
  endtask

  task automatic lookup(logic [1:0] kind, logic [31:0] va, logic [7:0] asid, string tag);
    setLookup(kind, va, asid);
    stepCycle(tag);
  endtask

  task automatic setFill(logic [19:0] vpn, logic [7:0] asid, logic [19:0] ppn,
                         logic [2:0] perm, logic g);
    fillValid = 1; fillVpn = vpn; fillAsid = asid; fillPpn = ppn;
    fillPerm = perm; fillGlobal = g;
  endtask

  task automatic fill(logic [19:0] vpn, logic [7:0] asid, logic [19:0] ppn,
                      logic [2:0] perm, logic g, string tag);
    setFill(vpn, asid, ppn, perm, g);
    stepCycle(tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failCount++;
    testCount++;
    $display("FAIL watchdog R2: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: reset outputs
    check("R1", "rspValid", 32'(rspValid), 0);
    check("R1", "walkReq", 32'(walkReq), 0);
    check("R1", "rspPaddr", rspPaddr, 0);
    lookup(2'd1, 32'h1234_5678, 8'd1, "R1_firstMiss");
    lookup(2'd0, 32'h0000_0000, 8'd0, "R1_zeroMiss");
    stepCycle("R2_idle");
    // R9: fill then retry, with a same-cycle lookup seeing old contents
    setFill(20'h12345, 8'd1, 20'hABCDE, 3'b011, 0);
    setLookup(2'd1, 32'h1234_5678, 8'd1);
    stepCycle("R9_sameCycle");
    lookup(2'd1, 32'h1234_5678, 8'd1, "R9_retryLoad");
    lookup(2'd2, 32'h1234_5FFC, 8'd1, "R5_storeOk");
    lookup(2'd0, 32'h1234_5000, 8'd1, "R5_fetchFault");
    lookup(2'd3, 32'h1234_5000, 8'd1, "R5_rsvdFault");
    // R6: foreign tag misses, global entry matches any tag
    lookup(2'd1, 32'h1234_5678, 8'd2, "R6_foreignTag");
    fill(20'h00400, 8'd3, 20'h00077, 3'b100, 1, "R6_fillGlobal");
    lookup(2'd0, 32'h0040_0ABC, 8'd5, "R6_globalFetch");
    lookup(2'd1, 32'h0040_0ABC, 8'd9, "R5_globalNoRead");
    // R7: fill the remaining slots, then wrap
    fill(20'h20000, 8'd3, 20'h30000, 3'b111, 0, "R7_fill2");
    fill(20'h20001, 8'd3, 20'h30001, 3'b001, 0, "R7_fill3");
    fill(20'h20002, 8'd4, 20'h30002, 3'b010, 0, "R7_fill4");
    for (int k = 0; k < 3; k++)
      fill(20'h21000 + 20'(k), 8'd6, 20'h31000 + 20'(k), 3'b111, 0, "R7_fillMore");
    lookup(2'd1, 32'h1234_5678, 8'd1, "R7_beforeWrap");
    fill(20'h22000, 8'd7, 20'h32000, 3'b101, 0, "R7_ninthFill");
    lookup(2'd1, 32'h1234_5678, 8'd1, "R7_evicted");
    lookup(2'd0, 32'h2200_0010, 8'd7, "R7_newSlot0");
    lookup(2'd1, 32'h2000_0444, 8'd3, "R8_preFlush");
    // R8: flush tag 3 (global entry also carries tag 3)
    flushValid = 1; flushAsid = 8'd3;
    stepCycle("R8_flush");
    lookup(2'd1, 32'h2000_0444, 8'd3, "R8_flushedA");
    lookup(2'd1, 32'h2000_1444, 8'd3, "R8_flushedB");
    lookup(2'd2, 32'h2000_2444, 8'd4, "R8_otherTagKept");
    lookup(2'd0, 32'h0040_0004, 8'd3, "R8_globalKept");
    // R8: flush and fill in the same cycle on the same tag
    flushValid = 1; flushAsid = 8'd8;
    setFill(20'h23000, 8'd8, 20'h33000, 3'b001, 0);
    stepCycle("R8_flushWithFill");
    lookup(2'd1, 32'h2300_0123, 8'd8, "R8_fillSurvives");
    // back-to-back mixed pattern
    for (int k = 0; k < 24; k++)
      lookup(2'(k % 4), {20'h21000 + 20'(k % 5), 12'(k * 37)}, 8'(k % 3 == 0 ? 6 : 7), "R2_stream");
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule